// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Unit

This block holds the pending-interrupt flags and the interrupt enables of a small peripheral and turns them into one interrupt request line. Each of the seven interrupt sources (counters, a shift register, handshake pins and the like, all outside this block) raises its own flag with a one-cycle pulse. Software sees two byte-wide registers through a simple synchronous strobe interface, one holding the flags and one holding the enables. The peripheral's other register accesses can also clear individual flags through per-source clear strobes.

Flags are cleared by writing ones to the flag register. Enables are set or cleared by a single write: the top data bit chooses whether the remaining ones set or clear the matching enable bits. The top bit of the flag register is not stored. It reads back as a live summary showing whether any flag is both pending and enabled. The request output is registered, so it lags the flag and enable state by one clock.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, the flag register reads 0x00, the enable register reads 0x80 and `irq` is 0. Reset is asynchronous on assertion and released synchronously; the block leaves reset two clock edges after `rst_n` rises.
- R2: `irq` is a register. After each clock edge it equals the OR, over bits 6..0, of flag AND enable as they stood before that edge.
- R3: A write to the enable register (`reg_sel`=1) with `wdata[7]`=1 ORs `wdata[6:0]` into the enables.
- R4: A write to the enable register with `wdata[7]`=0 clears every enable bit whose data bit is 1. All other enables are unchanged.
- R5: A read of the enable register returns the enables in bits 6..0, with bit 7 always 1.
- R6: A read of the flag register (`reg_sel`=0) returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag is both set and enabled, and it is computed from the current flags and enables.
- R7: A write to the flag register clears each flag whose data bit is 1. Zero bits leave their flags unchanged, and the enables are not affected.
- R8: A pulse on `src_set[i]` sets flag i at the next clock edge.
- R9: A pulse on `src_clr[i]` clears flag i at the next clock edge.
- R10: When flag i is set and cleared in the same cycle, by strobe or by register write, the set wins and the flag ends up 1.
- R11: A write to the enable register leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| src_set | input | 7 | Per-source flag set pulses |
| src_clr | input | 7 | Per-source flag clear strobes from other register accesses |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The bench sweeps all 128 enable patterns against all 128 flag patterns. For each pair it checks the summary bit on a flag read and the delayed `irq`. A design that computed the summary from the flags alone, or drove `irq` without the register stage, would fail in many of those cells. Each sweep step clears the flags by a write while setting them by pulse in the same cycle, so a design that let clear win would read back zeros. Directed steps check that zero bits in a clear write and in an enable-clear write leave their bits alone. They also check that a set-mode enable write with bit 7 high never clears existing enables, and that writes to either register leave the other register's contents unchanged.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_EN   = 1'b1
  } irqu_sel_e;
endpackage

// File: rtl/irqu_rst_sync.sv
module irqu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqu_flag_reg.sv
module irqu_flag_reg #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_clr_en,
  input  logic [NUM_SRC-1:0] wr_clr_mask,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] flag_d;
  logic [NUM_SRC-1:0] bit_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic kill;
    always_comb begin
      kill      = src_clr[i] | (wr_clr_en & wr_clr_mask[i]);
      bit_en[i] = src_set[i] | kill;
      // set has priority over any clear in the same cycle
      flag_d[i] = src_set[i] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (bit_en[i]) flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/irqu_enable_reg.sv
module irqu_enable_reg #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               set_mode,
  input  logic [NUM_SRC-1:0] wr_mask,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] en_d;
  logic [NUM_SRC-1:0] bit_we;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      bit_we[i] = wr_en & wr_mask[i];
      en_d[i]   = set_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q[i] <= 1'b0;
      else if (bit_we[i]) en_q[i] <= en_d[i];
    end
  end
endmodule

// File: rtl/irqu_read_irq.sv
module irqu_read_irq #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic [NUM_SRC-1:0] flag_q,
  input  logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC:0]   rdata,
  output logic               irq
);
  import irqu_pkg::*;

  logic any_active;
  logic irq_d;
  logic irq_q;

  always_comb begin
    any_active = |(flag_q & en_q);
    irq_d      = any_active;
    if (irqu_sel_e'(reg_sel) == SEL_EN) rdata = {1'b1, en_q};
    else                                rdata = {any_active, flag_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               reg_sel,
  input  logic [NUM_SRC:0]   wdata,
  output logic [NUM_SRC:0]   rdata,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  output logic               irq
);
  import irqu_pkg::*;

  localparam int MODE_BIT = NUM_SRC;

  logic               rst_sync_n;
  logic               wr_flag;
  logic               wr_enable;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;

  always_comb begin
    wr_flag   = wr_en & (irqu_sel_e'(reg_sel) == SEL_FLAG);
    wr_enable = wr_en & (irqu_sel_e'(reg_sel) == SEL_EN);
  end

  irqu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irqu_flag_reg #(.NUM_SRC(NUM_SRC)) u_flag (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_clr_en(wr_flag), .wr_clr_mask(wdata[NUM_SRC-1:0]),
    .src_set(src_set), .src_clr(src_clr), .flag_q(flag_q)
  );

  irqu_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_enable), .set_mode(wdata[MODE_BIT]),
    .wr_mask(wdata[NUM_SRC-1:0]), .en_q(en_q)
  );

  irqu_read_irq #(.NUM_SRC(NUM_SRC)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .reg_sel(reg_sel),
    .flag_q(flag_q), .en_q(en_q), .rdata(rdata), .irq(irq)
  );
endmodule

// File: rtl/irqu_checker.sv
module irqu_checker #(
  parameter int NUM_SRC = 7
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               wr_en,
  input logic               reg_sel,
  input logic [NUM_SRC:0]   wdata,
  input logic [NUM_SRC:0]   rdata,
  input logic [NUM_SRC-1:0] src_set,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               irq
);
  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> irq == $past(|(flag_q & en_q))); // R2
  AST_EN_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && reg_sel && wdata[NUM_SRC]) |=>
      ((en_q & $past(wdata[NUM_SRC-1:0] | en_q)) == $past(wdata[NUM_SRC-1:0] | en_q))); // R3
  AST_EN_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && reg_sel && !wdata[NUM_SRC]) |=> ((en_q & $past(wdata[NUM_SRC-1:0])) == '0)); // R4
  AST_EN_READ_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_sel |-> rdata[NUM_SRC]); // R5
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !reg_sel) |=> ((flag_q & $past(wdata[NUM_SRC-1:0] & ~src_set)) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|src_set) |=> ((flag_q & $past(src_set)) == $past(src_set))); // R10
  AST_EN_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && reg_sel && src_set == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R11
endmodule

bind irq_flag_unit irqu_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .reg_sel(reg_sel),
  .wdata(wdata), .rdata(rdata), .src_set(src_set), .flag_q(flag_q),
  .en_q(en_q), .irq(irq)
);

// File: tb/irq_flag_unit_tb.sv
`timescale 1ns/1ps
module irq_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [6:0] src_set = 7'h00;
  logic [6:0] src_clr = 7'h00;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] m_fl = 7'h00;
  logic [6:0] m_en = 7'h00;
  logic       m_irq = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .src_set(src_set), .src_clr(src_clr), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, return at next negedge with inputs idle
  task automatic op(logic w, logic s, logic [7:0] d, logic [6:0] st, logic [6:0] cl);
    wr_en = w; reg_sel = s; wdata = d; src_set = st; src_clr = cl;
    m_irq = |(m_fl & m_en);
    if (w && !s) m_fl = m_fl & ~d[6:0];
    if (w && s)  m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    m_fl = (m_fl & ~cl) | st;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00; src_set = 7'h00; src_clr = 7'h00;
  endtask

  task automatic read_chk(string req, logic s);
    reg_sel = s; #1;
    if (s) check(req, rdata, {1'b1, m_en});
    else   check(req, rdata, {|(m_fl & m_en), m_fl});
  endtask

  task automatic irq_chk(string req);
    check(req, {7'h00, irq}, {7'h00, m_irq});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_chk("R1 flag", 1'b0);
    read_chk("R1 en", 1'b1);
    check("R1 irq", {7'h00, irq}, 8'h00);

    // R8 set pulses, R2 lag: irq stays low one cycle
    op(1, 1, 8'h85, 7'h00, 7'h00);        // R3 set enables 0,2
    read_chk("R3 en set", 1'b1);
    op(0, 0, 8'h00, 7'h04, 7'h00);        // R8 set flag 2
    read_chk("R8 flag set", 1'b0);        // R6 summary high
    check("R2 irq lag", {7'h00, irq}, 8'h00);
    op(0, 0, 8'h00, 7'h00, 7'h00);
    irq_chk("R2 irq rise");
    check("R2 irq one", {7'h00, irq}, 8'h01);

    // R3 set-mode write never clears others
    op(1, 1, 8'h80 | 8'h10, 7'h00, 7'h00);
    read_chk("R3 add only", 1'b1);
    check("R3 en value", rdata, 8'h95);
    // R4 clear mode, zero bits untouched
    op(1, 1, 8'h04, 7'h00, 7'h00);
    read_chk("R4 en clear", 1'b1);
    check("R4 en value", rdata, 8'h91);
    read_chk("R11 flags kept", 1'b0);     // flag 2 still set, summary 0
    check("R11 flag value", rdata, 8'h04);

    // R7 write-one-to-clear with zero bits keeping flags
    op(0, 0, 8'h00, 7'h7F, 7'h00);
    op(1, 0, 8'h0A, 7'h00, 7'h00);
    read_chk("R7 w1c", 1'b0);
    check("R7 flag value", rdata, {1'b1, 7'h75});
    read_chk("R7 en kept", 1'b1);
    // R9 clear strobes
    op(0, 0, 8'h00, 7'h00, 7'h21);
    read_chk("R9 strobe clr", 1'b0);
    check("R9 flag value", rdata, {1'b1, 7'h54});
    // R10 set beats strobe clear
    op(0, 0, 8'h00, 7'h40, 7'h40);
    read_chk("R10 set wins strobe", 1'b0);
    op(1, 0, 8'h7F, 7'h00, 7'h00);
    irq_chk("R2 irq before clear");
    op(0, 0, 8'h00, 7'h00, 7'h00);
    irq_chk("R2 irq fall");

    // exhaustive sweep: enables x flags, flags loaded by clear-write + set pulse
    for (int e = 0; e < 128; e++) begin
      op(1, 1, 8'h7F, 7'h00, 7'h00);
      op(1, 1, 8'h80 | 8'(e), 7'h00, 7'h00);
      read_chk("R5 sweep en", 1'b1);
      for (int f = 0; f < 128; f++) begin
        op(1, 0, 8'h7F, 7'(f), 7'h00);    // R10 set wins over write clear
        read_chk("R6 R10 sweep flag", 1'b0);
        irq_chk("R2 sweep irq prev");
        op(0, 0, 8'h00, 7'h00, 7'h00);
        irq_chk("R2 sweep irq");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule